// File: doc/BRIEF.md
# Bank-Set Search Sequencer with Partial Tags

This block runs tag lookups for one bank set of a banked cache whose lines move between banks. The ways of the set are numbered by distance: way 0 sits in the bank nearest the controller and the highest way in the farthest bank. For each lookup the sequencer sends probe pulses to the banks in the order set by a run-time search policy. It gathers the hit/miss replies, which return after any number of cycles. It then finishes with a single-cycle completion pulse that carries a hit flag and the way that hit.

A small array inside the controller keeps the low tag bits of every line. Each fill or swap writes this array through a dedicated port. The lookup can run with this filter off. In performance mode the filter declares a miss at once when no stored partial tag matches. In energy mode it probes the nearest bank first and, only if that bank misses, the farther banks whose partial tags match. A partial-tag match is only a hint, and the real bank replies always decide the outcome.

Top module: `bankset_search_seq`

## Requirements
- R1: After reset `req_ready` is 1, `probe_valid` is all zero and `done`, `done_hit` and `early_miss` are 0.
- R2: With `search_mode` 0 (incremental), banks are probed one per step, starting at way 0 and going up. The search stops at the first step whose reply hits. If way NUM_WAYS-1 also misses, the lookup ends as a miss.
- R3: With `search_mode` 1 (full multicast), every way is probed in one single-cycle pulse, and the outcome follows from those replies alone.
- R4: With `search_mode` 2 (limited multicast), ways 0..LIMIT_M-1 are probed together. The remaining ways are then probed one per step in ascending order.
- R5: With `search_mode` 3 (partitioned multicast), the set is split into consecutive groups of PART_SIZE ways. The groups are probed one after another from way 0 upward, and all ways of a group are probed in the same cycle.
- R6: A new step is issued only after every bank of the current step has replied. The outcome is decided in the cycle after the last reply. `done` pulses for one cycle. On a hit, `done_hit`=1 and `done_way` is the lowest way that hit in that step. On a miss, `done_hit`=0. `done_hit` and `early_miss` are 0 whenever `done` is 0.
- R7: With `filter_mode` 1 (performance), if no stored partial tag of the set equals the low PTAG_W bits of `req_tag`, no bank is probed. `done` and `early_miss` are both 1 in the cycle after acceptance, and `done_hit` is 0.
- R8: With `filter_mode` 1 and at least one partial-tag match, the probes and the outcome are the same as with the filter off (`filter_mode` 0 or 3).
- R9: With `filter_mode` 2 (energy), `search_mode` is ignored. Way 0 is probed alone. If it misses, every other way whose partial tag matches is probed in one pulse. If none matches, the lookup ends as a miss with no further probes.
- R10: When a partial tag matches but the full tag in the bank does not, the lookup still ends with `done_hit`=0 once the probed banks have replied.
- R11: A write with `pt_wr_en` stores `pt_wr_ptag` for way `pt_wr_way` of set `pt_wr_set`. Lookups accepted in later cycles use the new value.
- R12: Only one lookup is accepted at a time. `req_ready` is 0 from acceptance until the completion cycle, except after an early miss. `probe_set` and `probe_tag` hold the request. No bank is probed twice in one lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request, taken when `req_ready` is 1 |
| req_ready | output | 1 | Sequencer idle and able to take a lookup |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Full tag of the lookup |
| search_mode | input | 2 | 0 incremental, 1 multicast, 2 limited, 3 partitioned |
| filter_mode | input | 2 | 0/3 off, 1 performance, 2 energy |
| probe_valid | output | NUM_WAYS | One-cycle probe pulse per bank, bit i = way i |
| probe_set | output | SET_W | Set index sent with the probes |
| probe_tag | output | TAG_W | Tag sent with the probes |
| reply_valid | input | NUM_WAYS | Bank i has replied to its probe |
| reply_hit | input | NUM_WAYS | Bank i's tag matched, valid with `reply_valid` |
| pt_wr_en | input | 1 | Partial-tag array write strobe |
| pt_wr_set | input | SET_W | Set written |
| pt_wr_way | input | WAY_W | Way written |
| pt_wr_ptag | input | PTAG_W | Partial tag written |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Lookup hit |
| done_way | output | WAY_W | Way that hit |
| early_miss | output | 1 | Miss decided from partial tags without probing |

## Verification
The bench uses a bank model whose reply delay varies from probe to probe, so replies within one step arrive out of order. A design that moved on after the first reply, rather than after the last, would probe banks too early and would show up as a wrong probe set. For every lookup the bench compares the exact set of banks probed with the set the policy requires. An off-by-one in the limited-multicast boundary or in the partition boundary therefore shows up as an extra or a missing bank. The corner cases are these: false partial-tag matches, which must still end in a miss rather than a hit on the hinted way; a performance-mode lookup with no match, which must finish in one cycle with no probes; an energy-mode miss at way 0 with no other match; and a partial tag rewritten just before a lookup, where a design that used stale values would skip the rewritten way.

// File: rtl/nuca_search_pkg.sv
package nuca_search_pkg;

   typedef enum logic [1:0] {
      SRCH_INCR  = 2'd0,
      SRCH_BCAST = 2'd1,
      SRCH_LIMIT = 2'd2,
      SRCH_PART  = 2'd3
   } srch_mode_e;

   typedef enum logic [1:0] {
      FILT_OFF    = 2'd0,
      FILT_PERF   = 2'd1,
      FILT_ENERGY = 2'd2,
      FILT_NONE   = 2'd3
   } filt_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   // index of the lowest set bit, 0 when empty
   function automatic int unsigned low_idx(input logic [31:0] v);
      int unsigned r;
      r = 0;
      for (int i = 31; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/nuca_ptag_array.sv
module nuca_ptag_array #(
   parameter int NUM_WAYS = 8,
   parameter int SET_W    = 3,
   parameter int PTAG_W   = 4,
   localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
   localparam int SETS    = 1 << SET_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SET_W-1:0]    wr_set,
   input  logic [WAY_W-1:0]    wr_way,
   input  logic [PTAG_W-1:0]   wr_ptag,
   input  logic [SET_W-1:0]    rd_set,
   input  logic [PTAG_W-1:0]   rd_ptag,
   output logic [NUM_WAYS-1:0] match
);

   logic [PTAG_W-1:0] mem_q [SETS][NUM_WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
               mem_q[s][w] <= '0;
      end else if (wr_en) begin
         mem_q[wr_set][wr_way] <= wr_ptag;
      end
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign match[w] = (mem_q[rd_set][w] == rd_ptag);
   end

endmodule

// File: rtl/nuca_group_sel.sv
module nuca_group_sel
   import nuca_search_pkg::*;
#(
   parameter int NUM_WAYS  = 8,
   parameter int LIMIT_M   = 2,
   parameter int PART_SIZE = 4,
   localparam int NUM_PART = NUM_WAYS / PART_SIZE
) (
   input  srch_mode_e          mode,
   input  logic [NUM_WAYS-1:0] issued,
   output logic [NUM_WAYS-1:0] grp
);

   logic [NUM_WAYS-1:0] rem, lowest, part_grp;
   logic [NUM_WAYS-1:0] part_hit [NUM_PART];

   assign rem    = ~issued;
   assign lowest = rem & (~rem + 1'b1);

   for (genvar p = 0; p < NUM_PART; p++) begin : g_part
      localparam logic [NUM_WAYS-1:0] PMASK =
         {{(NUM_WAYS-PART_SIZE){1'b0}}, {PART_SIZE{1'b1}}} << (p * PART_SIZE);
      assign part_hit[p] = ((lowest & PMASK) != '0) ? (rem & PMASK) : '0;
   end

   always_comb begin
      part_grp = '0;
      for (int p = 0; p < NUM_PART; p++) part_grp |= part_hit[p];
   end

   localparam logic [NUM_WAYS-1:0] LIM_MASK =
      {{(NUM_WAYS-LIMIT_M){1'b0}}, {LIMIT_M{1'b1}}};

   always_comb begin
      unique case (mode)
         SRCH_INCR:  grp = lowest;
         SRCH_BCAST: grp = rem;
         SRCH_LIMIT: grp = (issued == '0) ? LIM_MASK : lowest;
         SRCH_PART:  grp = part_grp;
         default:    grp = lowest;
      endcase
   end

endmodule

// File: rtl/bankset_search_seq.sv
module bankset_search_seq
   import nuca_search_pkg::*;
#(
   parameter int NUM_WAYS  = 8,
   parameter int TAG_W     = 16,
   parameter int SET_W     = 3,
   parameter int PTAG_W    = 4,
   parameter int LIMIT_M   = 2,
   parameter int PART_SIZE = 4,
   localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [SET_W-1:0]    req_set,
   input  logic [TAG_W-1:0]    req_tag,
   input  logic [1:0]          search_mode,
   input  logic [1:0]          filter_mode,
   output logic [NUM_WAYS-1:0] probe_valid,
   output logic [SET_W-1:0]    probe_set,
   output logic [TAG_W-1:0]    probe_tag,
   input  logic [NUM_WAYS-1:0] reply_valid,
   input  logic [NUM_WAYS-1:0] reply_hit,
   input  logic                pt_wr_en,
   input  logic [SET_W-1:0]    pt_wr_set,
   input  logic [WAY_W-1:0]    pt_wr_way,
   input  logic [PTAG_W-1:0]   pt_wr_ptag,
   output logic                done,
   output logic                done_hit,
   output logic [WAY_W-1:0]    done_way,
   output logic                early_miss
);

   if (NUM_WAYS < 2 || NUM_WAYS > 32) begin : g_bad_ways
      $error("NUM_WAYS must lie in 2..32");
   end
   if (LIMIT_M < 1 || LIMIT_M > NUM_WAYS) begin : g_bad_lim
      $error("LIMIT_M must lie in 1..NUM_WAYS");
   end
   if (PART_SIZE < 1 || (NUM_WAYS % PART_SIZE) != 0) begin : g_bad_part
      $error("PART_SIZE must divide NUM_WAYS");
   end
   if (PTAG_W < 1 || PTAG_W > TAG_W) begin : g_bad_ptag
      $error("PTAG_W must lie in 1..TAG_W");
   end

   localparam logic [NUM_WAYS-1:0] NEAR_ONLY = {{(NUM_WAYS-1){1'b0}}, 1'b1};

   seq_state_e          state_q;
   srch_mode_e          smode_q, sel_mode;
   filt_mode_e          fmode_q, fmode_in;
   logic [SET_W-1:0]    set_q;
   logic [TAG_W-1:0]    tag_q;
   logic [NUM_WAYS-1:0] match_now, match_q;
   logic [NUM_WAYS-1:0] issued_q, grp_q, got_q, hit_q, probe_q;
   logic [NUM_WAYS-1:0] sel_issued, sel_grp, next_grp;
   logic                done_q, dhit_q, early_q;
   logic [WAY_W-1:0]    dway_q;

   assign fmode_in   = filt_mode_e'(filter_mode);
   assign sel_mode   = (state_q == SEQ_IDLE) ? srch_mode_e'(search_mode) : smode_q;
   assign sel_issued = (state_q == SEQ_IDLE) ? '0 : issued_q;

   nuca_ptag_array #(
      .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .PTAG_W(PTAG_W)
   ) u_ptag (
      .clk(clk), .rst_n(rst_n),
      .wr_en(pt_wr_en), .wr_set(pt_wr_set), .wr_way(pt_wr_way), .wr_ptag(pt_wr_ptag),
      .rd_set(req_set), .rd_ptag(req_tag[PTAG_W-1:0]), .match(match_now)
   );

   nuca_group_sel #(
      .NUM_WAYS(NUM_WAYS), .LIMIT_M(LIMIT_M), .PART_SIZE(PART_SIZE)
   ) u_grp (
      .mode(sel_mode), .issued(sel_issued), .grp(sel_grp)
   );

   assign next_grp = (fmode_q == FILT_ENERGY) ? (match_q & ~issued_q) : sel_grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         smode_q  <= SRCH_INCR;
         fmode_q  <= FILT_OFF;
         set_q    <= '0;
         tag_q    <= '0;
         match_q  <= '0;
         issued_q <= '0;
         grp_q    <= '0;
         got_q    <= '0;
         hit_q    <= '0;
         probe_q  <= '0;
         done_q   <= 1'b0;
         dhit_q   <= 1'b0;
         dway_q   <= '0;
         early_q  <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         dhit_q  <= 1'b0;
         dway_q  <= '0;
         early_q <= 1'b0;
         probe_q <= '0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  set_q   <= req_set;
                  tag_q   <= req_tag;
                  smode_q <= srch_mode_e'(search_mode);
                  fmode_q <= fmode_in;
                  match_q <= match_now;
                  got_q   <= '0;
                  hit_q   <= '0;
                  if (fmode_in == FILT_PERF && match_now == '0) begin
                     done_q  <= 1'b1;
                     early_q <= 1'b1;
                  end else if (fmode_in == FILT_ENERGY) begin
                     probe_q  <= NEAR_ONLY;
                     grp_q    <= NEAR_ONLY;
                     issued_q <= NEAR_ONLY;
                     state_q  <= SEQ_WAIT;
                  end else begin
                     probe_q  <= sel_grp;
                     grp_q    <= sel_grp;
                     issued_q <= sel_grp;
                     state_q  <= SEQ_WAIT;
                  end
               end
            end
            SEQ_WAIT: begin
               if (got_q == grp_q) begin
                  if (hit_q != '0) begin
                     done_q  <= 1'b1;
                     dhit_q  <= 1'b1;
                     dway_q  <= WAY_W'(low_idx(32'(hit_q)));
                     state_q <= SEQ_IDLE;
                  end else if (next_grp == '0) begin
                     done_q  <= 1'b1;
                     state_q <= SEQ_IDLE;
                  end else begin
                     probe_q  <= next_grp;
                     grp_q    <= next_grp;
                     issued_q <= issued_q | next_grp;
                     got_q    <= '0;
                     hit_q    <= '0;
                  end
               end else begin
                  got_q <= got_q | (reply_valid & grp_q);
                  hit_q <= hit_q | (reply_valid & reply_hit & grp_q);
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == SEQ_IDLE);
   assign probe_valid = probe_q;
   assign probe_set   = set_q;
   assign probe_tag   = tag_q;
   assign done        = done_q;
   assign done_hit    = dhit_q;
   assign done_way    = dway_q;
   assign early_miss  = early_q;

endmodule

// File: rtl/nuca_search_chk.sv
module nuca_search_chk #(
   parameter int NUM_WAYS = 8,
   parameter int WAY_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [NUM_WAYS-1:0] probe_valid,
   input logic                done,
   input logic                done_hit,
   input logic [WAY_W-1:0]    done_way,
   input logic                early_miss
);

   logic [NUM_WAYS-1:0] probed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      probed_q <= '0;
      else if (req_valid && req_ready) probed_q <= '0;
      else                             probed_q <= probed_q | probe_valid;
   end

   // R12
   no_reprobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid & probed_q) == '0);

   // R12
   busy_while_probing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid != '0) |-> !req_ready);

   // R6
   hit_way_probed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_hit) |-> probed_q[done_way]);

   // R6
   flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!done_hit && !early_miss));

   // R7
   early_no_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early_miss |-> (!done_hit && probed_q == '0));

endmodule

bind bankset_search_seq nuca_search_chk #(
   .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
) u_search_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .probe_valid(probe_valid), .done(done), .done_hit(done_hit),
   .done_way(done_way), .early_miss(early_miss)
);

// File: tb/bankset_search_seq_test.sv
`timescale 1ns/1ps
module bankset_search_seq_test;

   localparam int N  = 8;
   localparam int TW = 16;
   localparam int SW = 3;
   localparam int PW = 4;
   localparam int LM = 2;
   localparam int PS = 4;
   localparam int WW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [SW-1:0] req_set = '0;
   logic [TW-1:0] req_tag = '0;
   logic [1:0]    search_mode = '0;
   logic [1:0]    filter_mode = '0;
   logic [N-1:0]  probe_valid;
   logic [SW-1:0] probe_set;
   logic [TW-1:0] probe_tag;
   logic [N-1:0]  reply_valid = '0;
   logic [N-1:0]  reply_hit = '0;
   logic          pt_wr_en = 1'b0;
   logic [SW-1:0] pt_wr_set = '0;
   logic [WW-1:0] pt_wr_way = '0;
   logic [PW-1:0] pt_wr_ptag = '0;
   logic          done, done_hit, early_miss;
   logic [WW-1:0] done_way;

   int n_chk = 0;
   int n_bad = 0;
   logic [TW-1:0] tagstore [8][N];
   int cnt [N];

   always #10 clk = ~clk;

   bankset_search_seq #(
      .NUM_WAYS(N), .TAG_W(TW), .SET_W(SW), .PTAG_W(PW), .LIMIT_M(LM), .PART_SIZE(PS)
   ) uut (.*);

   // bank model: reply 1..3 cycles after each probe
   initial begin
      for (int w = 0; w < N; w++) cnt[w] = 0;
      forever begin
         @(negedge clk);
         reply_valid = '0;
         reply_hit   = '0;
         for (int w = 0; w < N; w++) begin
            if (cnt[w] > 0) begin
               cnt[w]--;
               if (cnt[w] == 0) begin
                  reply_valid[w] = 1'b1;
                  reply_hit[w]   = (tagstore[probe_set][w] == probe_tag);
               end
            end
            if (probe_valid[w]) cnt[w] = 1 + int'($urandom % 3);
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_tag(input int s, input int w, input logic [TW-1:0] t);
      tagstore[s][w] = t;
      @(negedge clk);
      pt_wr_en = 1'b1; pt_wr_set = SW'(s); pt_wr_way = WW'(w); pt_wr_ptag = t[PW-1:0];
      @(negedge clk);
      pt_wr_en = 1'b0;
   endtask

   function automatic int gid(input int w, input logic [1:0] sm);
      case (sm)
         2'd0:    return w;
         2'd1:    return 0;
         2'd2:    return (w < LM) ? 0 : w - LM + 1;
         default: return w / PS;
      endcase
   endfunction

   task automatic expect_res(input int s, input logic [TW-1:0] t, input logic [1:0] sm,
                             input logic [1:0] fm, output bit eh, output int ew,
                             output logic [N-1:0] ep, output bit ee);
      logic [N-1:0] h, p, c;
      int g;
      for (int w = 0; w < N; w++) begin
         h[w] = (tagstore[s][w] == t);
         p[w] = (tagstore[s][w][PW-1:0] == t[PW-1:0]);
      end
      eh = 0; ew = 0; ep = '0; ee = 0;
      if (fm == 2'd1 && p == '0) begin
         ee = 1;
      end else if (fm == 2'd2) begin
         if (h[0]) begin eh = 1; ep = 1; end
         else begin
            c = p & ~N'(1);
            ep = c | N'(1);
            if ((h & c) != '0) begin
               eh = 1;
               for (int w = N - 1; w >= 0; w--) if (h[w] && c[w]) ew = w;
            end
         end
      end else if (h != '0) begin
         eh = 1;
         for (int w = N - 1; w >= 0; w--) if (h[w]) ew = w;
         g = gid(ew, sm);
         for (int w = 0; w < N; w++) ep[w] = (gid(w, sm) <= g);
      end else begin
         ep = '1;
      end
   endtask

   task automatic lookup(input int s, input logic [TW-1:0] t, input logic [1:0] sm,
                         input logic [1:0] fm, input string tagp, input string tagh);
      bit eh, ee, got;
      int ew;
      logic [N-1:0] ep, seen;
      expect_res(s, t, sm, fm, eh, ew, ep, ee);
      @(negedge clk);
      req_valid = 1'b1; req_set = SW'(s); req_tag = t;
      search_mode = sm; filter_mode = fm;
      @(negedge clk);
      req_valid = 1'b0;
      if (!ee) check(!req_ready && probe_set == SW'(s) && probe_tag == t,
                     "R12 busy and request held", int'(req_ready), 0);
      seen = '0; got = 0;
      for (int c = 0; c < 200 && !got; c++) begin
         seen |= probe_valid;
         if (done) got = 1;
         else @(negedge clk);
      end
      check(got, "R6 completion pulse", int'(got), 1);
      check(seen == ep, tagp, int'(seen), int'(ep));
      check(done_hit == eh, tagh, int'(done_hit), int'(eh));
      if (eh) check(done_way == WW'(ew), "R6 hit way", int'(done_way), ew);
      check(early_miss == ee, "R7 early miss flag", int'(early_miss), int'(ee));
      @(negedge clk);
      check(!done, "R6 done one cycle", int'(done), 0);
   endtask

   function automatic string mode_tag(input logic [1:0] sm, input logic [1:0] fm);
      if (fm == 2'd2) return "R9 energy probes";
      if (fm == 2'd1) return "R8 filtered probes";
      case (sm)
         2'd0:    return "R2 incremental probes";
         2'd1:    return "R3 multicast probes";
         2'd2:    return "R4 limited probes";
         default: return "R5 partitioned probes";
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [TW-1:0] t;
      int s, w, kind;
      logic [1:0] sm, fm;
      void'($urandom(32'h1357));
      for (int a = 0; a < 8; a++) for (int b = 0; b < N; b++) tagstore[a][b] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready && probe_valid == '0 && !done && !done_hit && !early_miss,
            "R1 reset state", int'({req_ready, done, done_hit, early_miss}), 8);
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < N; b++)
            write_tag(a, b, TW'($urandom));
      // directed: set 7 partial tags are 0..7
      for (int b = 0; b < N; b++) write_tag(7, b, {12'(b * 37 + 5), 4'(b)});
      // R7 no partial match: early miss, nothing probed
      lookup(7, 16'hABCF, 2'd0, 2'd1, "R7 no probes", "R7 miss");
      // R2 incremental hit at farthest way, and full miss
      lookup(7, tagstore[7][7], 2'd0, 2'd0, "R2 incremental to far way", "R2 hit");
      lookup(7, 16'h0EEF, 2'd0, 2'd0, "R2 incremental full miss", "R2 miss");
      // R3 multicast
      lookup(7, tagstore[7][5], 2'd1, 2'd0, "R3 multicast probes", "R3 hit");
      // R4 boundary: first single after the parallel group
      lookup(7, tagstore[7][LM], 2'd2, 2'd0, "R4 limited boundary", "R4 hit");
      // R5 boundary: first way of second partition
      lookup(7, tagstore[7][PS], 2'd3, 2'd3, "R5 partition boundary", "R5 hit");
      // R10 false partial match at way 3 in both filter modes
      lookup(7, {tagstore[7][3][15:4] ^ 12'hFFF, 4'd3}, 2'd0, 2'd1, "R10 perf probes", "R10 false hint miss");
      lookup(7, {tagstore[7][3][15:4] ^ 12'hFFF, 4'd3}, 2'd0, 2'd2, "R10 energy probes", "R10 false hint miss");
      // R9 energy: nearest hit, and no further match
      lookup(7, tagstore[7][0], 2'd1, 2'd2, "R9 nearest only", "R9 nearest hit");
      lookup(7, {tagstore[7][0][15:4] ^ 12'h001, 4'd0}, 2'd1, 2'd2, "R9 nearest only miss", "R9 miss");
      // R11 rewrite way 6 then hit it through its new partial tag
      write_tag(7, 6, 16'h9A5C);
      lookup(7, 16'h9A5C, 2'd0, 2'd2, "R11 rewritten way probed", "R11 hit new tag");
      // random mix
      for (int i = 0; i < 400; i++) begin
         s = int'($urandom % 8);
         w = int'($urandom % N);
         kind = int'($urandom % 3);
         sm = 2'($urandom);
         fm = 2'($urandom);
         if (kind == 0)      t = tagstore[s][w];
         else if (kind == 1) t = {tagstore[s][w][15:4] ^ 12'(1 + $urandom % 4095), tagstore[s][w][3:0]};
         else                t = TW'($urandom);
         lookup(s, t, sm, fm, mode_tag(sm, fm), "R6 hit flag");
         if ((i % 50) == 49) write_tag(s, w, TW'($urandom));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule